// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the 16x oversampling strobe for a serial port from a faster reference clock. The divisor has two parts: an integer count of reference clocks, and a fraction in sixty-fourths. The output is a one-cycle pulse. A single counter cannot divide by a non-integer value, so the block dithers instead. Every period starts by adding the fraction to a six-bit accumulator. When that addition wraps, the period is lengthened by one reference clock, so the long-run pulse rate matches integer plus fraction over 64.

Software computes one number: the reference clock divided by (baud x 16 / 64). The upper bits go to the integer input and the low six bits go to the fraction input. The fraction is therefore the fractional part of (reference / (16 x baud)) times 64, rounded. For example, a 4 MHz reference at 230400 baud gives integer 1 and fraction 5, an effective divisor of 1 + 5/64. Both inputs are sampled only when a new period starts, so software may rewrite them at any time without producing a malformed period.

Top module: `baud_frac_gen`

## Requirements
- R1: The reset input is synchronous and active high. While it is high, and on the cycle after it falls, `tick` is low. Reset clears the period counter and the fraction accumulator. With integer 2 and fraction 63, the gaps after reset are therefore 2, 3, 3, 3 cycles.
- R2: While `en` is low, no tick appears, starting with the first clock edge that samples `en` low. A low `en` also clears the counter and the accumulator, so the next enabled run starts from an accumulator of zero.
- R3: A period starts at the first edge that samples `en` high with a non-zero integer divisor I while the block is idle. `tick` is then seen high for one cycle, I edges later. With fraction 0, every later tick follows the previous one by exactly I cycles. I = 1 gives a tick on every cycle.
- R4: At the start of each period, the fraction F is added to a 6-bit accumulator. If the sum is 64 or more, that period lasts I+1 cycles and the accumulator keeps the sum minus 64. Otherwise the period lasts I cycles.
- R5: Over any 64 consecutive periods with constant I and F, the total length is 64·I+F cycles. Integer 1 with fraction 5 gives 69 cycles for 64 ticks.
- R6: If the integer input reads 0 when a period ends, that period still ends with its tick, and then the block goes idle with no further ticks. The accumulator keeps its value. A later non-zero integer starts a new period at the next edge.
- R7: Divisor changes made in the middle of a period do not alter that period. They apply from the next period boundary.
- R8: The full range works: integer 65535 with fraction 63, starting from an accumulator of zero, gives gaps of 65535 and then 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable; low forces idle and clears state |
| div_int | input | 16 | Integer divisor in reference clocks; 0 stops generation |
| div_frac | input | 6 | Fractional divisor in sixty-fourths |
| tick | output | 1 | One-cycle pulse at 16 times the baud rate |

## Verification
Two things can happen on the same clock edge: the end of one period, which raises `tick`, and the sampling of the divisor inputs for the next period. The bench provokes this by rewriting the divisors on the falling edge right after each tick. With an integer of 1, the very next rising edge is both a tick and a reload. The scoreboard model carries over the period that was already loaded with the old values. It expects the new values only from the following period, so a design that samples the divisor one edge early or late produces a gap mismatch. The stop case is judged the same way: the integer is cleared just after a tick, one more tick is expected, and then silence.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;

    // Default divisor field widths
    localparam int DEF_INT_W  = 16;
    localparam int DEF_FRAC_W = 6;

    // Generator state: idle waits for a non-zero divisor, run counts a period
    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    // Period length for one period: integer part plus the dither carry
    function automatic logic [DEF_INT_W:0] period_len(
        input logic [DEF_INT_W-1:0] ival,
        input logic                 carry
    );
        return {1'b0, ival} + {{DEF_INT_W{1'b0}}, carry};
    endfunction

endpackage

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign carry = sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/baud_period_ctr.sv
module baud_period_ctr #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_frac_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    localparam int CNT_W = INT_W + 1;

    gen_state_e       state_q;
    logic             period_end;
    logic             boundary;
    logic             div_nz;
    logic             step;
    logic             carry;
    logic [CNT_W-1:0] load_val;
    logic             tick_q;

    assign div_nz   = |div_int;
    assign boundary = (state_q == GEN_IDLE) || period_end;
    assign step     = en && boundary && div_nz;

    generate
        if (INT_W == DEF_INT_W) begin : g_pkg_len
            assign load_val = period_len(div_int, carry);
        end else begin : g_gen_len
            assign load_val = CNT_W'(div_int) + CNT_W'(carry);
        end
    endgenerate

    baud_frac_acc #(
        .FRAC_W (FRAC_W)
    ) i_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (!en),
        .step  (step),
        .frac  (div_frac),
        .carry (carry)
    );

    baud_period_ctr #(
        .CNT_W (CNT_W)
    ) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .clr      (!en),
        .load     (step),
        .load_val (load_val),
        .last     (period_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= en && (state_q == GEN_RUN) && period_end;
            if (!en) begin
                state_q <= GEN_IDLE;
            end else if (boundary) begin
                state_q <= div_nz ? GEN_RUN : GEN_IDLE;
            end
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              tick
);

    localparam int GAP_W = INT_W + 2;

    logic [INT_W-1:0]  div_d_i;
    logic [FRAC_W-1:0] div_d_f;
    logic [INT_W-1:0]  prev_i;
    logic [FRAC_W-1:0] prev_f;
    logic              have_prev;
    logic              stopped;
    logic [GAP_W-1:0]  gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_d_i   <= '0;
            div_d_f   <= '0;
            prev_i    <= '0;
            prev_f    <= '0;
            have_prev <= 1'b0;
            stopped   <= 1'b1;
            gap       <= '0;
        end else begin
            div_d_i <= div_int;
            div_d_f <= div_frac;
            if (tick) begin
                gap    <= GAP_W'(1);
                prev_i <= div_d_i;
                prev_f <= div_d_f;
            end else if (gap != '1) begin
                gap <= gap + GAP_W'(1);
            end
            if (!en) begin
                have_prev <= 1'b0;
                stopped   <= 1'b1;
            end else begin
                if (tick) begin
                    have_prev <= (div_d_i != '0);
                end
                stopped <= (stopped || (tick && (div_d_i == '0))) && (div_int == '0);
            end
        end
    end

    // R2: enable low silences the output from the next edge
    a_r2_no_tick_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick);

    // R6 and R1: idle after reset, disable or a zero divisor gives no pulse
    a_r6_idle_silent: assert property (@(posedge clk) disable iff (rst)
        stopped |-> !tick);

    // R7 and R4: each gap uses the divisor sampled at its start, plus at most one
    a_r7_period_bounds: assert property (@(posedge clk) disable iff (rst)
        (tick && have_prev) |->
            ((gap == GAP_W'(prev_i)) || (gap == GAP_W'(prev_i) + GAP_W'(1))));

    // R3: with no fraction the gap is exactly the integer divisor
    a_r3_period_exact: assert property (@(posedge clk) disable iff (rst)
        (tick && have_prev && (prev_f == '0)) |-> (gap == GAP_W'(prev_i)));

endmodule

bind baud_frac_gen baud_frac_gen_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .div_int  (div_int),
    .div_frac (div_frac),
    .tick     (tick)
);

// File: tb/test_baud_frac_gen.sv
`timescale 1ns/1ps
module test_baud_frac_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] div_int = '0;
    logic [5:0]  div_frac = '0;
    logic        tick;

    baud_frac_gen i_baud_frac_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick     (tick)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int unsigned len;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          errors = 0;
    int          checks = 0;
    int          unexpected = 0;
    int unsigned cyc = 0;
    int unsigned last_edge = 0;
    longint      obs_sum = 0;
    string       quiet_tag = "R1";
    int unsigned m_acc = 0;
    bit          m_run = 1'b0;
    int unsigned m_pend = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each observed gap with the next scoreboard entry
    always @(negedge clk) begin : mon
        exp_t e;
        if (tick === 1'b1) begin
            if (sb.size() == 0) begin
                unexpected++;
                check(1'b0, quiet_tag, 1, 0);
            end else begin
                e = sb.pop_front();
                check((cyc - last_edge) == e.len, e.tag, longint'(cyc - last_edge), longint'(e.len));
                obs_sum += longint'(cyc - last_edge);
            end
            last_edge = cyc;
        end
    end

    // Reference model of one period start (R4, R6)
    function automatic int unsigned model_load(input int unsigned i, input int unsigned f);
        int unsigned s;
        if (i == 0) begin
            m_run = 1'b0;
            return 0;
        end
        s     = m_acc + f;
        m_acc = s % 64;
        return i + ((s >= 64) ? 1 : 0);
    endfunction

    task automatic step_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (sb.size() != 0) step_neg();
    endtask

    task automatic run_cfg(input int unsigned i, input int unsigned f, input int n, input string tag);
        div_int  = i[15:0];
        div_frac = f[5:0];
        en       = 1'b1;
        if (!m_run) begin
            last_edge = cyc + 1;
            m_pend    = model_load(i, f);
            m_run     = 1'b1;
        end
        for (int k = 0; k < n; k++) begin
            sb.push_back('{len: m_pend, tag: tag});
            m_pend = model_load(i, f);
        end
        drain();
    endtask

    task automatic quiet(input int n, input string tag);
        int u0;
        quiet_tag = tag;
        u0 = unexpected;
        repeat (n) step_neg();
        check((unexpected == u0) && (tick == 1'b0), tag, longint'(unexpected - u0), 0);
    endtask

    task automatic stop_gen(input string tag);
        div_int = '0;
        sb.push_back('{len: m_pend, tag: tag});
        void'(model_load(0, 0));
        drain();
        quiet(30, tag);
    endtask

    task automatic disable_gen(input string tag);
        en    = 1'b0;
        m_run = 1'b0;
        m_acc = 0;
        quiet(20, tag);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : driver
        // R1: reset dominates even with enable and divisor present
        en      = 1'b1;
        div_int = 16'd5;
        step_neg();
        check(tick == 1'b0, "R1", longint'(tick), 0);
        quiet(4, "R1");
        rst = 1'b0;

        // R3: integer-only periods, including a pulse every cycle
        run_cfg(5, 0, 6, "R3");
        run_cfg(1, 0, 8, "R3");

        // R7: change divisor right after a tick; the loaded period keeps the old value
        run_cfg(4, 0, 3, "R7");
        run_cfg(2, 0, 4, "R7");
        run_cfg(1, 0, 3, "R7");
        run_cfg(3, 0, 3, "R7");

        // R2: enable low stops output and clears the accumulator
        disable_gen("R2");

        // R5: 64 ticks at 1 + 5/64 total 69 cycles
        obs_sum = 0;
        run_cfg(1, 5, 64, "R5");
        check(obs_sum == 69, "R5", obs_sum, 69);

        // R4: dithered periods from a non-zero accumulator
        run_cfg(3, 40, 6, "R4");

        // R6: zero divisor lets the loaded period finish, then idles; restart keeps accumulator
        stop_gen("R6");
        run_cfg(3, 40, 5, "R6");

        // R1: mid-run reset clears the accumulator; gaps 2,3,3,3
        rst   = 1'b1;
        m_run = 1'b0;
        m_acc = 0;
        quiet(3, "R1");
        rst     = 1'b0;
        obs_sum = 0;
        run_cfg(2, 63, 4, "R1");
        check(obs_sum == 11, "R1", obs_sum, 11);

        // R8: widest divisor
        disable_gen("R2");
        obs_sum = 0;
        run_cfg(65535, 63, 2, "R8");
        check(obs_sum == 131071, "R8", obs_sum, 131071);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule